// File: doc/BRIEF.md
# BCD Clock Calendar with Read Freeze

This block keeps wall-clock time and date in a bank of packed BCD counters: seconds, minutes, hours, day of month, weekday, month and two-digit year. Each register holds the tens digit in its upper nibble. A one-cycle pulse on `tick_1hz` advances the bank by one second, and carries ripple through the calendar as needed. Month lengths follow the calendar, and a leap February applies when the two-digit year is a multiple of four.

A host reaches the counters through a flat register port. Address 0 is seconds, with a reset flag in bit 7. Addresses 1 to 6 are minutes, hours, day, weekday, month and year. Address 7 is the control register: bit 0 stops counting and bit 1 selects 12-hour format. While `rd_en` is high the counters are frozen, so a multi-register read cannot see a half-finished carry. One tick that arrives during the freeze is held back and applied in the first cycle after `rd_en` falls.

In 12-hour format the hour register carries a PM flag in bit 5 and a BCD hour from 01 to 12 in bits 4:0.

Top module: `rtc_calendar`

## Requirements
- R1: After a synchronous reset, reads return seconds 8'h80 (flag set, zero seconds), minutes 00, hours 00, day 01, weekday 0, month 01, year 00 and control 00 (24-hour format, running).
- R2: Each accepted tick adds one second in BCD; 59 seconds wraps to 00 and increments minutes; 59 minutes wraps to 00 and increments hours.
- R3: While `rd_en` is high no counter changes. Any number of ticks during that time are recorded as a single tick, and that tick is applied on the clock edge that ends the first cycle with `rd_en` low.
- R4: In 24-hour format (control bit 1 = 0) the hour runs 00 to 23, and 23 wraps to 00 with a carry into the day.
- R5: In 12-hour format (control bit 1 = 1) hours bits 4:0 run 12, 01, ..., 11. The change from 11 to 12 toggles bit 5 (1 = PM), and the change from 11 PM to 12 AM carries into the day.
- R6: The day wraps to 01 after 31 in months 01, 03, 05, 07, 08, 10 and 12, after 30 in months 04, 06, 09 and 11, and in month 02 after 29 when the year is divisible by 4, otherwise after 28.
- R7: A day wrap increments the month, and month 12 wraps to 01 with a carry into the year. Year 99 wraps to 00. The weekday increments on every day carry and wraps from 6 to 0.
- R8: While control bit 0 (stop) is 1, ticks are ignored and any held tick is discarded.
- R9: Seconds bit 7 is the reset flag. Reset sets it to 1, and a write to address 0 loads it from write bit 7.
- R10: Bits that are not implemented read as 0. The stored widths are: seconds 7 bits, minutes 7, hours 6, day 6, weekday 3, month 5, year 8, control 2.
- R11: A write to the seconds register discards a held tick or a coinciding tick. A tick that coincides with a write to any other address is held and applied in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| rd_en | input | 1 | Host read in progress; freezes the counters |
| wr_en | input | 1 | Write strobe for `wdata` into `addr` |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |

## Verification
The assertions assume that `tick_1hz` is a single-cycle pulse and that a write may land on any cycle, including during a freeze. For that reason, every property about held state excludes write cycles rather than assuming writes never overlap reads. The stimulus drives every input on the falling edge and pulses each tick for exactly one cycle. It writes only valid BCD values in the vector walk, so the calendar sequences the properties and checks rely on are always well formed. Out-of-range values are written only in the unused-bit test, and the bank is reloaded before any tick follows.

// File: rtl/rtc_cal_pkg.sv
// Shared types and BCD helpers for the clock calendar.
// Assumes all BCD operands hold digits 0..9 in each nibble.
package rtc_cal_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_SEC  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MIN  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOUR = 3'd2;
    localparam logic [ADDR_W-1:0] A_DAY  = 3'd3;
    localparam logic [ADDR_W-1:0] A_WDAY = 3'd4;
    localparam logic [ADDR_W-1:0] A_MON  = 3'd5;
    localparam logic [ADDR_W-1:0] A_YEAR = 3'd6;
    localparam logic [ADDR_W-1:0] A_CTL  = 3'd7;

    typedef struct packed {
        logic [DATA_W-1:0] year;
        logic [DATA_W-1:0] mon;
        logic [DATA_W-1:0] wday;
        logic [DATA_W-1:0] day;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] sec;
    } rtc_time_t;

    // Add one to a two-digit BCD value (no wrap at 99 handled here).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return v + 8'd1;
    endfunction

    // Last day of a BCD month, leap rule on the two-digit BCD year.
    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] year);
        logic [7:0] ybin;
        ybin = ({4'd0, year[7:4]} * 8'd10) + {4'd0, year[3:0]};
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'd0) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_tick_defer.sv
// Decides when the counter bank steps. Holds at most one tick while the
// bank is frozen or a write owns the cycle; assumes tick is a 1-cycle pulse.
module rtc_tick_defer (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic freeze,
    input  logic stop,
    input  logic wr_any,
    input  logic wr_sec,
    output logic step,
    output logic pending
);
    // Step when unfrozen, running, no write, and a tick is new or held.
    always_comb step = !freeze && !stop && !wr_any && (tick || pending);

    // Track the single held tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                 pending <= 1'b0;
        else if (stop || wr_sec)    pending <= 1'b0;
        else if (step)              pending <= 1'b0;
        else if (tick)              pending <= 1'b1;
    end
endmodule

// File: rtl/rtc_time_next.sv
// Combinational one-second successor of a BCD time/date value.
// Assumes every field holds a valid BCD value for the selected hour format.
module rtc_time_next
    import rtc_cal_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      mode12,
    output rtc_time_t nxt
);
    logic       c_min, c_hour, c_day, c_mon, c_year, pm;
    logic [7:0] h_inc, dim;

    always_comb h_inc = bcd_inc({3'b000, cur.hour[4:0]});
    always_comb dim   = month_len(cur.mon, cur.year);

    // Ripple the carry from seconds up to years.
    always_comb begin
        nxt    = cur;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        pm     = cur.hour[5];
        c_min  = (cur.sec == 8'h59);
        nxt.sec = c_min ? 8'h00 : bcd_inc(cur.sec);
        if (c_min) begin
            c_hour  = (cur.min == 8'h59);
            nxt.min = c_hour ? 8'h00 : bcd_inc(cur.min);
        end
        if (c_hour) begin
            if (mode12) begin
                if (cur.hour[4:0] == 5'h11) begin
                    nxt.hour = {2'b00, ~pm, 5'h12};
                    c_day    = pm;
                end else if (cur.hour[4:0] == 5'h12) begin
                    nxt.hour = {2'b00, pm, 5'h01};
                end else begin
                    nxt.hour = {2'b00, pm, h_inc[4:0]};
                end
            end else begin
                c_day    = (cur.hour == 8'h23);
                nxt.hour = c_day ? 8'h00 : bcd_inc(cur.hour);
            end
        end
        if (c_day) begin
            nxt.wday = (cur.wday >= 8'd6) ? 8'd0 : cur.wday + 8'd1;
            c_mon    = (cur.day == dim);
            nxt.day  = c_mon ? 8'h01 : bcd_inc(cur.day);
        end
        if (c_mon) begin
            c_year  = (cur.mon == 8'h12);
            nxt.mon = c_year ? 8'h01 : bcd_inc(cur.mon);
        end
        if (c_year) nxt.year = (cur.year == 8'h99) ? 8'h00 : bcd_inc(cur.year);
    end
endmodule

// File: rtl/rtc_calendar.sv
// Clock calendar top: register bank, host port and read-freeze control.
// Assumes host writes valid BCD; rdata follows addr combinationally.
module rtc_calendar
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    rtc_time_t time_q, time_nxt;
    logic      rst_flag, ctl_stop, ctl_12h, step, pending, wr_sec;

    always_comb wr_sec = wr_en && (addr == A_SEC);

    rtc_tick_defer u_defer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_1hz),
        .freeze  (rd_en),
        .stop    (ctl_stop),
        .wr_any  (wr_en),
        .wr_sec  (wr_sec),
        .step    (step),
        .pending (pending)
    );

    rtc_time_next u_next (
        .cur    (time_q),
        .mode12 (ctl_12h),
        .nxt    (time_nxt)
    );

    // Register bank: reset, host writes (masked to field widths), or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q   <= '{year: 8'h00, mon: 8'h01, wday: 8'h00, day: 8'h01,
                          hour: 8'h00, min: 8'h00, sec: 8'h00};
            rst_flag <= 1'b1;
            ctl_stop <= 1'b0;
            ctl_12h  <= 1'b0;
        end else if (wr_en) begin
            case (addr)
                A_SEC:  begin
                            time_q.sec <= {1'b0, wdata[6:0]};
                            rst_flag   <= wdata[7];
                        end
                A_MIN:  time_q.min  <= {1'b0, wdata[6:0]};
                A_HOUR: time_q.hour <= {2'b00, wdata[5:0]};
                A_DAY:  time_q.day  <= {2'b00, wdata[5:0]};
                A_WDAY: time_q.wday <= {5'b00000, wdata[2:0]};
                A_MON:  time_q.mon  <= {3'b000, wdata[4:0]};
                A_YEAR: time_q.year <= wdata;
                default: begin
                            ctl_12h  <= wdata[1];
                            ctl_stop <= wdata[0];
                        end
            endcase
        end else if (step) begin
            time_q <= time_nxt;
        end
    end

    // Read mux; stored fields are already masked, unused bits are zero.
    always_comb begin
        case (addr)
            A_SEC:   rdata = {rst_flag, time_q.sec[6:0]};
            A_MIN:   rdata = time_q.min;
            A_HOUR:  rdata = time_q.hour;
            A_DAY:   rdata = time_q.day;
            A_WDAY:  rdata = time_q.wday;
            A_MON:   rdata = time_q.mon;
            A_YEAR:  rdata = time_q.year;
            default: rdata = {6'd0, ctl_12h, ctl_stop};
        endcase
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
// Property checker for rtc_calendar, attached by bind below.
// Assumes tick is a single-cycle pulse; writes may occur at any time.
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       rd_en,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] rdata,
    input logic       pending,
    input logic       stop,
    input logic [7:0] sec
);
    // R3: a frozen, write-free cycle leaves the addressed value unchanged.
    p_freeze_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> (addr != $past(addr) || $stable(rdata)));

    // R3: a tick landing in a freeze is held.
    p_tick_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rd_en && !stop && !(wr_en && addr == 3'd0)) |=> pending);

    // R3: a held tick is applied once the freeze releases.
    p_release_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !rd_en && !wr_en && !stop) |=> (!pending && sec != $past(sec)));

    // R8: stopped counters do not move and drop any held tick.
    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !wr_en) |=> ($stable(sec) && !pending));

    // R11: a seconds write discards any held tick.
    p_sec_write_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0) |=> !pending);
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_1hz),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .addr    (addr),
    .rdata   (rdata),
    .pending (pending),
    .stop    (ctl_stop),
    .sec     (time_q.sec)
);

// File: tb/tb_rtc_calendar.sv
// Self-checking bench: vector walk over carry cases, then directed tests.
module tb_rtc_calendar;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_1hz = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    int         n_checks = 0;
    int         n_errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    rtc_calendar dut (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .rd_en(rd_en),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Entry: ctl,year,mon,wday,day,hour,min,sec | year,mon,wday,day,hour,min,sec
    localparam int NV = 16;
    localparam logic [119:0] VEC [NV] = '{
        120'h00_00_01_00_01_00_00_00__00_01_00_01_00_00_01, // R2
        120'h00_00_01_00_01_00_05_59__00_01_00_01_00_06_00, // R2
        120'h00_00_01_00_01_09_59_59__00_01_00_01_10_00_00, // R2
        120'h00_24_06_03_15_23_59_59__24_06_04_16_00_00_00, // R4
        120'h00_23_02_06_28_23_59_59__23_03_00_01_00_00_00, // R6
        120'h00_24_02_01_28_23_59_59__24_02_02_29_00_00_00, // R6
        120'h00_24_02_02_29_23_59_59__24_03_03_01_00_00_00, // R6
        120'h00_10_04_04_30_23_59_59__10_05_05_01_00_00_00, // R6
        120'h00_10_05_04_30_23_59_59__10_05_05_31_00_00_00, // R6
        120'h00_99_12_05_31_23_59_59__00_01_06_01_00_00_00, // R7
        120'h00_09_12_05_31_23_59_59__10_01_06_01_00_00_00, // R7
        120'h02_24_03_01_10_11_59_59__24_03_01_10_32_00_00, // R5
        120'h02_24_03_02_05_31_59_59__24_03_03_06_12_00_00, // R5
        120'h02_24_03_01_10_12_59_59__24_03_01_10_01_00_00, // R5
        120'h02_24_03_01_10_09_59_59__24_03_01_10_10_00_00, // R5
        120'h02_24_03_01_10_32_59_59__24_03_01_10_21_00_00  // R5
    };
    localparam int TAG [NV] = '{2, 2, 2, 4, 6, 6, 6, 6, 6, 7, 7, 5, 5, 5, 5, 5};

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Combinational read between edges; leaves rd_en as it found it.
    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        logic keep;
        keep = rd_en;
        rd_en = 1'b1; addr = a;
        #2 d = rdata;
        rd_en = keep;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [55:0] got;
        logic [119:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R9: reset contents
        rd(3'd0, v); check("R9 reset flag", v, 8'h80);
        rd(3'd1, v); check("R1 min", v, 8'h00);
        rd(3'd2, v); check("R1 hour", v, 8'h00);
        rd(3'd3, v); check("R1 day", v, 8'h01);
        rd(3'd4, v); check("R1 wday", v, 8'h00);
        rd(3'd5, v); check("R1 mon", v, 8'h01);
        rd(3'd6, v); check("R1 year", v, 8'h00);
        rd(3'd7, v); check("R1 ctl", v, 8'h00);

        // Vector walk: load, one tick, read back all time fields
        for (int i = 0; i < NV; i++) begin
            e = VEC[i];
            wr(3'd7, e[119:112]);
            for (int k = 0; k < 7; k++) wr(3'(6 - k), e[111 - 8*k -: 8]);
            pulse_tick();
            for (int k = 0; k < 7; k++) begin
                rd(3'(6 - k), v);
                got[55 - 8*k -: 8] = v;
            end
            check($sformatf("R%0d vector %0d", TAG[i], i), {8'd0, got}, {8'd0, e[55:0]});
        end

        // R3: freeze, several ticks, counters held, one step after release
        wr(3'd7, 8'h00); wr(3'd0, 8'h00);
        @(negedge clk); rd_en = 1'b1; addr = 3'd0;
        repeat (3) pulse_tick();
        repeat (2) @(negedge clk);
        check("R3 frozen", rdata, 8'h00);
        rd_en = 1'b0;
        @(negedge clk);
        rd(3'd0, v); check("R3 one deferred tick applied", v, 8'h01);
        repeat (4) @(negedge clk);
        rd(3'd0, v); check("R3 only one tick kept", v, 8'h01);

        // R8: stopped counter ignores ticks, held tick discarded
        wr(3'd7, 8'h01);
        pulse_tick();
        @(negedge clk); rd_en = 1'b1;
        pulse_tick();
        rd_en = 1'b0;
        wr(3'd7, 8'h00);
        repeat (2) @(negedge clk);
        rd(3'd0, v); check("R8 stop ignores ticks", v, 8'h01);

        // R11: seconds write discards a held tick
        @(negedge clk); rd_en = 1'b1;
        pulse_tick();
        wr(3'd0, 8'h10);
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rd(3'd0, v); check("R11 seconds write drops held tick", v, 8'h10);
        // R11: tick coinciding with a minute write applies next cycle
        @(negedge clk);
        wr_en = 1'b1; addr = 3'd1; wdata = 8'h42; tick_1hz = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick_1hz = 1'b0;
        @(negedge clk);
        rd(3'd0, v); check("R11 deferred past other write", v, 8'h11);
        rd(3'd1, v); check("R11 minute written", v, 8'h42);

        // R10: unused bits read zero
        wr(3'd0, 8'hFF); rd(3'd0, v); check("R10 sec", v, 8'hFF);
        wr(3'd1, 8'hFF); rd(3'd1, v); check("R10 min", v, 8'h7F);
        wr(3'd2, 8'hFF); rd(3'd2, v); check("R10 hour", v, 8'h3F);
        wr(3'd3, 8'hFF); rd(3'd3, v); check("R10 day", v, 8'h3F);
        wr(3'd4, 8'hFF); rd(3'd4, v); check("R10 wday", v, 8'h07);
        wr(3'd5, 8'hFF); rd(3'd5, v); check("R10 mon", v, 8'h1F);
        wr(3'd6, 8'hFF); rd(3'd6, v); check("R10 year", v, 8'hFF);
        wr(3'd7, 8'hFF); rd(3'd7, v); check("R10 ctl", v, 8'h03);

        // R9: flag follows write bit 7, and reset sets it again
        wr(3'd0, 8'h25); rd(3'd0, v); check("R9 flag cleared", v, 8'h25);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(3'd0, v); check("R9 flag set by reset", v, 8'h80);
        rd(3'd7, v); check("R1 ctl after reset", v, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule